// File: doc/BRIEF.md
# MSI Snooping Writeback Cache Controller

This block is the coherence controller of one private cache in a shared-bus multiprocessor. It holds a small direct-mapped array of one-word lines. Every line carries one of three ownership states: Invalid (no copy), Shared (clean, possibly also held elsewhere, memory current) or Modified (dirty, the only valid copy). The cache is writeback and write-allocate.

Processor reads and writes that the line state allows are served locally. All other accesses become bus requests. A read miss asks for a shared copy. A write to a line that is not owned asks for an exclusive copy. A dirty line that must be replaced is first written back to memory. At the same time the controller watches read and read-exclusive requests from other caches. When it owns the requested line it drives the word onto the bus and flags that it supplied the data. It then drops the line to Shared or Invalid, depending on the kind of request.

A bench or a bus agent drives the request acknowledge and the returned data. Arbitration and memory timing are outside the block.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After a synchronous reset every line is Invalid, so the first processor access to any address goes to the bus.
- R2: A processor read whose line is Invalid or holds another tag requests a shared copy (bus_req_cmd = 1). When bus_ack arrives it completes, returns bus_rdata and leaves the line Shared.
- R3: A processor write to a line that is Shared, Invalid or holds another tag requests an exclusive copy (bus_req_cmd = 2). When bus_ack arrives it completes and leaves the line Modified, holding the written word.
- R4: A read that hits a Shared or Modified line, and a write that hits a Modified line, raise pr_done one cycle after the request is taken and raise no bus request. pr_rdata gives the line word after the access.
- R5: A snooped read (snp_excl = 0) that hits a Modified line raises snp_flush one cycle later, with the line word on snp_data, and leaves the line Shared.
- R6: A snooped read-exclusive (snp_excl = 1) that hits a Modified line flushes in the same way and leaves the line Invalid. When it hits a Shared line, the line becomes Invalid without a flush.
- R7: A snooped read that hits a Shared line causes no flush, and the line stays Shared.
- R8: On a miss whose victim is Modified, a writeback (bus_req_cmd = 3) is issued first, carrying the victim's address (old tag with the same index) and its word. Only after that request is acknowledged is the read or read-exclusive issued. A clean victim gets no writeback.
- R9: snp_flush is high exactly in the cycles in which this cache supplies snooped data, and snp_data is zero in all other cycles.
- R10: A snoop that arrives while the controller is idle is serviced in that cycle ahead of a processor request presented in the same cycle. That request is acted on in a later cycle, against the updated line state.
- R11: A snoop whose address does not match a valid line leaves that line's state unchanged and causes no flush.
- R12: A bus request stays valid with unchanged command and address until bus_ack. The command codes are 0 none, 1 read, 2 read-exclusive and 3 writeback. Addresses are word addresses: the low IDX_W bits are the line index and the rest is the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pr_valid | input | 1 | Processor request present; held until pr_done |
| pr_write | input | 1 | 1 = write, 0 = read |
| pr_addr | input | ADDR_W | Processor word address |
| pr_wdata | input | DATA_W | Processor write word |
| pr_done | output | 1 | One-cycle completion pulse |
| pr_rdata | output | DATA_W | Line word after the access |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 1 read, 2 read-exclusive, 3 writeback |
| bus_req_addr | output | ADDR_W | Request word address |
| bus_req_data | output | DATA_W | Writeback word |
| bus_ack | input | 1 | Current request completes this cycle |
| bus_rdata | input | DATA_W | Fill word, valid with bus_ack |
| snp_valid | input | 1 | Another cache's request is visible |
| snp_excl | input | 1 | 0 = snooped read, 1 = snooped read-exclusive |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_flush | output | 1 | This cache supplies the snooped word |
| snp_data | output | DATA_W | Supplied word, zero otherwise |

## Verification
A wrong line state is invisible at the ports until that line is touched again. A line wrongly left Modified shows up as a spurious flush on the next snoop or as an extra writeback on eviction. A line wrongly left valid shows up as a missing bus request, and a lost Modified state shows up as a missing flush. Each of these differs from the reference in the cycle right after the access that exposes it. For that reason the stimulus revisits every line under snoops of both kinds, with matching and mismatching tags, and places snoops beside, during and at the completion of misses.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WB   = 2'd1,
    CS_FILL = 2'd2
  } ctl_st_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  pa_idx,
  output logic [ADDR_W-IDX_W-1:0] pa_tag,
  output logic [DATA_W-1:0] pa_data,
  output line_st_t          pa_st,
  input  logic [IDX_W-1:0]  sb_idx,
  output logic [ADDR_W-IDX_W-1:0] sb_tag,
  output logic [DATA_W-1:0] sb_data,
  output line_st_t          sb_st,
  input  logic              pw_en,
  input  logic [IDX_W-1:0]  pw_idx,
  input  logic [ADDR_W-IDX_W-1:0] pw_tag,
  input  logic [DATA_W-1:0] pw_data,
  input  line_st_t          pw_st,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_st
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];
  line_st_t          st_q     [LINES];

  // tag and data: plain single write port, no reset
  always_ff @(posedge clk) begin
    if (pw_en) begin
      tag_mem[pw_idx]  <= pw_tag;
      data_mem[pw_idx] <= pw_data;
    end
  end

  // state: processor-side write lands last and therefore wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_I;
    end else begin
      if (sw_en) st_q[sw_idx] <= sw_st;
      if (pw_en) st_q[pw_idx] <= pw_st;
    end
  end

  assign pa_tag  = tag_mem[pa_idx];
  assign pa_data = data_mem[pa_idx];
  assign pa_st   = st_q[pa_idx];
  assign sb_tag  = tag_mem[sb_idx];
  assign sb_data = data_mem[sb_idx];
  assign sb_st   = st_q[sb_idx];

  // R1: leaving reset, every line looked up is Invalid
  p_reset_invalid_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_st == LS_I && sb_st == LS_I));
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  look_idx,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  line_st_t          line_st,
  output logic              st_we,
  output line_st_t          st_new,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  logic match;
  logic flush_d;

  assign look_idx = snp_addr[IDX_W-1:0];
  assign match    = snp_valid && (line_st != LS_I) &&
                    (line_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign flush_d  = match && (line_st == LS_M);
  assign st_we    = match && ((line_st == LS_M) || snp_excl);
  assign st_new   = snp_excl ? LS_I : LS_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_flush <= 1'b0;
      snp_data  <= '0;
    end else begin
      snp_flush <= flush_d;
      snp_data  <= flush_d ? line_data : '0;
    end
  end

  // R9: a flush only ever answers a snoop seen the cycle before
  p_flush_answers_snoop_r9: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> $past(snp_valid));
endmodule

// File: rtl/msi_proc_ctrl.sv
module msi_proc_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pr_valid,
  input  logic              pr_write,
  input  logic [ADDR_W-1:0] pr_addr,
  input  logic [DATA_W-1:0] pr_wdata,
  input  logic              snp_valid,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  look_idx,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  line_st_t          line_st,
  output logic              pw_en,
  output logic [IDX_W-1:0]  pw_idx,
  output logic [ADDR_W-IDX_W-1:0] pw_tag,
  output logic [DATA_W-1:0] pw_data,
  output line_st_t          pw_st,
  output logic              pr_done,
  output logic [DATA_W-1:0] pr_rdata,
  output logic              bus_req_valid,
  output bus_cmd_t          bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_t           cs;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_write;
  logic [DATA_W-1:0] lat_wdata;

  logic [TAG_W-1:0]  req_tag;
  logic              tag_hit, go, local_ok, need_wb, fill;

  assign look_idx = pr_addr[IDX_W-1:0];
  assign req_tag  = pr_addr[ADDR_W-1:IDX_W];
  assign tag_hit  = (line_st != LS_I) && (line_tag == req_tag);
  assign go       = (cs == CS_IDLE) && pr_valid && !snp_valid;
  assign local_ok = tag_hit && (!pr_write || line_st == LS_M);
  assign need_wb  = !tag_hit && (line_st == LS_M);
  assign fill     = (cs == CS_FILL) && bus_ack;

  always_comb begin
    pw_en   = fill || (go && local_ok && pr_write);
    pw_idx  = fill ? lat_addr[IDX_W-1:0] : look_idx;
    pw_tag  = fill ? lat_addr[ADDR_W-1:IDX_W] : req_tag;
    pw_data = pr_wdata;
    pw_st   = LS_M;
    if (fill) begin
      pw_data = lat_write ? lat_wdata : bus_rdata;
      pw_st   = lat_write ? LS_M : LS_S;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs            <= CS_IDLE;
      lat_addr      <= '0;
      lat_write     <= 1'b0;
      lat_wdata     <= '0;
      pr_done       <= 1'b0;
      pr_rdata      <= '0;
      bus_req_valid <= 1'b0;
      bus_req_cmd   <= BC_NONE;
      bus_req_addr  <= '0;
      bus_req_data  <= '0;
    end else begin
      pr_done <= 1'b0;
      case (cs)
        CS_IDLE: begin
          if (go) begin
            if (local_ok) begin
              pr_done  <= 1'b1;
              pr_rdata <= pr_write ? pr_wdata : line_data;
            end else begin
              lat_addr      <= pr_addr;
              lat_write     <= pr_write;
              lat_wdata     <= pr_wdata;
              bus_req_valid <= 1'b1;
              if (need_wb) begin
                bus_req_cmd  <= BC_WB;
                bus_req_addr <= {line_tag, look_idx};
                bus_req_data <= line_data;
                cs           <= CS_WB;
              end else begin
                bus_req_cmd  <= pr_write ? BC_RDX : BC_RD;
                bus_req_addr <= pr_addr;
                cs           <= CS_FILL;
              end
            end
          end
        end
        CS_WB: begin
          if (bus_ack) begin
            bus_req_cmd  <= lat_write ? BC_RDX : BC_RD;
            bus_req_addr <= lat_addr;
            cs           <= CS_FILL;
          end
        end
        CS_FILL: begin
          if (bus_ack) begin
            bus_req_valid <= 1'b0;
            bus_req_cmd   <= BC_NONE;
            pr_done       <= 1'b1;
            pr_rdata      <= pw_data;
            cs            <= CS_IDLE;
          end
        end
        default: cs <= CS_IDLE;
      endcase
    end
  end

  // R12: a request waits unchanged for its acknowledge
  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && !bus_ack) |=>
      (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)));

  // R8: an acknowledged writeback is followed by the fetch of the new line
  p_wb_then_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_ack && bus_req_cmd == BC_WB) |=>
      (bus_req_valid && bus_req_cmd != BC_WB));

  // R4: completion never coincides with an open bus request
  p_done_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    pr_done |-> !bus_req_valid);

  // R10: an idle-cycle snoop holds off the processor side for that cycle
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (rst)
    (cs == CS_IDLE && snp_valid) |=> (!pr_done && !bus_req_valid));
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pr_valid,
  input  logic              pr_write,
  input  logic [ADDR_W-1:0] pr_addr,
  input  logic [DATA_W-1:0] pr_wdata,
  output logic              pr_done,
  output logic [DATA_W-1:0] pr_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  pa_idx, sb_idx, pw_idx;
  logic [TAG_W-1:0]  pa_tag, sb_tag, pw_tag;
  logic [DATA_W-1:0] pa_data, sb_data, pw_data;
  line_st_t          pa_st, sb_st, pw_st, sw_st;
  logic              pw_en, sw_en;
  bus_cmd_t          cmd_e;

  msi_line_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .pa_idx(pa_idx), .pa_tag(pa_tag), .pa_data(pa_data), .pa_st(pa_st),
    .sb_idx(sb_idx), .sb_tag(sb_tag), .sb_data(sb_data), .sb_st(sb_st),
    .pw_en(pw_en), .pw_idx(pw_idx), .pw_tag(pw_tag), .pw_data(pw_data), .pw_st(pw_st),
    .sw_en(sw_en), .sw_idx(sb_idx), .sw_st(sw_st)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .look_idx(sb_idx), .line_tag(sb_tag), .line_data(sb_data), .line_st(sb_st),
    .st_we(sw_en), .st_new(sw_st),
    .snp_flush(snp_flush), .snp_data(snp_data)
  );

  msi_proc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_proc (
    .clk(clk), .rst(rst),
    .pr_valid(pr_valid), .pr_write(pr_write), .pr_addr(pr_addr), .pr_wdata(pr_wdata),
    .snp_valid(snp_valid), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .look_idx(pa_idx), .line_tag(pa_tag), .line_data(pa_data), .line_st(pa_st),
    .pw_en(pw_en), .pw_idx(pw_idx), .pw_tag(pw_tag), .pw_data(pw_data), .pw_st(pw_st),
    .pr_done(pr_done), .pr_rdata(pr_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(cmd_e),
    .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data)
  );

  assign bus_req_cmd = cmd_e;
endmodule

// File: tb/sim_msi_cache_ctrl.sv
`timescale 1ns/1ps
module sim_msi_cache_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pv = 1'b0, pw = 1'b0, sv = 1'b0, sx = 1'b0, ack = 1'b0;
  logic [7:0]  pa = '0, sa = '0;
  logic [15:0] pwd = '0, ardata = '0;

  logic        pr_done, bus_req_valid, snp_flush;
  logic [15:0] pr_rdata, bus_req_data, snp_data;
  logic [1:0]  bus_req_cmd;
  logic [7:0]  bus_req_addr;

  always #10 clk = ~clk;

  msi_cache_ctrl u0 (
    .clk(clk), .rst(rst),
    .pr_valid(pv), .pr_write(pw), .pr_addr(pa), .pr_wdata(pwd),
    .pr_done(pr_done), .pr_rdata(pr_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
    .bus_ack(ack), .bus_rdata(ardata),
    .snp_valid(sv), .snp_excl(sx), .snp_addr(sa),
    .snp_flush(snp_flush), .snp_data(snp_data)
  );

  // reference model state
  int          m_st [4];
  logic [5:0]  m_tag [4];
  logic [15:0] m_dat [4];
  logic [15:0] mem [256];
  int          mode = 0;
  logic [7:0]  l_a = '0;
  logic        l_w = 1'b0;
  logic [15:0] l_d = '0;
  logic        e_done = 0, e_req_v = 0, e_flush = 0;
  logic [15:0] e_rdata = '0, e_req_data = '0, e_sdata = '0;
  logic [1:0]  e_req_cmd = '0;
  logic [7:0]  e_req_addr = '0;
  int          wait_cnt = 0;
  int          vectors = 0, fails = 0;
  bit          finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic model_step();
    int si = 0; int s_new = 0; bit s_we = 0; bit n_flush = 0; logic [15:0] n_sdata = '0;
    bit p_we = 0; int p_idx = 0; logic [5:0] p_tag = '0; logic [15:0] p_dat = '0; int p_st = 0;
    int pi; bit hit;
    if (rst) begin
      for (int i = 0; i < 4; i++) m_st[i] = 0;
      mode = 0; e_done = 0; e_rdata = '0; e_req_v = 0; e_req_cmd = '0;
      e_req_addr = '0; e_req_data = '0; e_flush = 0; e_sdata = '0; wait_cnt = 0;
      return;
    end
    if (sv) begin
      si = int'(sa[1:0]);
      if (m_st[si] != 0 && m_tag[si] == sa[7:2]) begin
        if (m_st[si] == 2) begin n_flush = 1; n_sdata = m_dat[si]; s_we = 1; end
        else if (sx) s_we = 1;
        s_new = sx ? 0 : 1;
      end
    end
    e_done = 0;
    case (mode)
      0: if (pv && !sv) begin
        pi  = int'(pa[1:0]);
        hit = (m_st[pi] != 0) && (m_tag[pi] == pa[7:2]);
        if (hit && (!pw || m_st[pi] == 2)) begin
          e_done = 1;
          if (pw) begin
            p_we = 1; p_idx = pi; p_tag = pa[7:2]; p_dat = pwd; p_st = 2; e_rdata = pwd;
          end else e_rdata = m_dat[pi];
        end else begin
          l_a = pa; l_w = pw; l_d = pwd; e_req_v = 1;
          if (!hit && m_st[pi] == 2) begin
            e_req_cmd = 2'd3; e_req_addr = {m_tag[pi], pa[1:0]}; e_req_data = m_dat[pi]; mode = 1;
          end else begin
            e_req_cmd = pw ? 2'd2 : 2'd1; e_req_addr = pa; mode = 2;
          end
        end
      end
      1: if (ack) begin
        mem[e_req_addr] = e_req_data;
        e_req_cmd = l_w ? 2'd2 : 2'd1; e_req_addr = l_a; mode = 2;
      end
      default: if (ack) begin
        e_req_v = 0; e_req_cmd = '0;
        p_we = 1; p_idx = int'(l_a[1:0]); p_tag = l_a[7:2];
        p_dat = l_w ? l_d : ardata; p_st = l_w ? 2 : 1;
        e_done = 1; e_rdata = p_dat; mode = 0;
      end
    endcase
    if (s_we) m_st[si] = s_new;
    if (p_we) begin m_st[p_idx] = p_st; m_tag[p_idx] = p_tag; m_dat[p_idx] = p_dat; end
    e_flush = n_flush; e_sdata = n_sdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    chk("R1 R2 R3 R4 R10 pr_done", 32'(pr_done), 32'(e_done));
    if (e_done) chk("R2 R3 R4 pr_rdata", 32'(pr_rdata), 32'(e_rdata));
    chk("R2 R3 R8 R12 bus_req_valid", 32'(bus_req_valid), 32'(e_req_v));
    if (e_req_v) begin
      chk("R2 R3 R8 R12 bus_req_cmd", 32'(bus_req_cmd), 32'(e_req_cmd));
      chk("R8 R12 bus_req_addr", 32'(bus_req_addr), 32'(e_req_addr));
      if (e_req_cmd == 2'd3) chk("R8 bus_req_data", 32'(bus_req_data), 32'(e_req_data));
    end
    chk("R5 R6 R7 R9 R11 snp_flush", 32'(snp_flush), 32'(e_flush));
    chk("R5 R6 R9 snp_data", 32'(snp_data), 32'(e_sdata));
  endtask

  // inputs are set at a falling edge; the model predicts the next rising edge
  task automatic tick();
    ack = 1'b0;
    if (e_req_v) begin
      if (wait_cnt == 2) begin ack = 1'b1; wait_cnt = 0; end
      else wait_cnt++;
    end
    ardata = mem[e_req_addr];
    model_step();
    @(negedge clk);
    ack = 1'b0;
    compare();
  endtask

  function automatic logic [7:0] rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic do_pr(input logic w, input logic [7:0] a, input logic [15:0] d, input int pct);
    logic [7:0] r;
    pv = 1'b1; pw = w; pa = a; pwd = d;
    for (int g = 0; g < 40; g++) begin
      if (pct > 0) begin
        r  = rnd8();
        sv = (int'(r) % 100) < pct;
        sx = r[7];
        sa = {4'd0, rnd8() % 8'd16};
      end
      tick();
      sv = 1'b0;
      if (e_done) break;
    end
    pv = 1'b0;
  endtask

  task automatic snoop(input logic x, input logic [7:0] a);
    sv = 1'b1; sx = x; sa = a;
    tick();
    sv = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 97 + 3);
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    rst = 1'b1;
    repeat (3) tick();                     // reset state of all outputs
    rst = 1'b0;
    tick();
    do_pr(1'b0, 8'h04, 16'h0, 0);          // R1 R2: first read misses, line Shared
    do_pr(1'b0, 8'h04, 16'h0, 0);          // R4: read hit, no bus
    do_pr(1'b1, 8'h04, 16'hA1A1, 0);       // R3: write on Shared -> read-exclusive
    do_pr(1'b1, 8'h04, 16'hB2B2, 0);       // R4: write hit on Modified
    do_pr(1'b0, 8'h04, 16'h0, 0);          // R4: read hit returns written word
    snoop(1'b0, 8'h04);                    // R5 R9: flush, to Shared
    do_pr(1'b0, 8'h04, 16'h0, 0);          // still valid: hit
    snoop(1'b0, 8'h04);                    // R7: Shared, no flush
    do_pr(1'b1, 8'h04, 16'hC3C3, 0);       // R3 again
    snoop(1'b1, 8'h04);                    // R6: flush, to Invalid
    do_pr(1'b0, 8'h04, 16'h0, 0);          // miss after invalidation
    snoop(1'b1, 8'h04);                    // R6: Shared silently invalidated
    do_pr(1'b0, 8'h04, 16'h0, 0);          // miss again
    snoop(1'b1, 8'h08);                    // R11: other tag, same index
    snoop(1'b0, 8'h03);                    // R11: Invalid line
    do_pr(1'b0, 8'h04, 16'h0, 0);          // R11: still a hit
    do_pr(1'b1, 8'h05, 16'hD4D4, 0);       // index 1 Modified
    do_pr(1'b0, 8'h09, 16'h0, 0);          // R8: writeback of 0x05 then read
    do_pr(1'b0, 8'h05, 16'h0, 0);          // R8: memory holds written word
    do_pr(1'b0, 8'h0D, 16'h0, 0);          // R8: clean victim, no writeback
    do_pr(1'b1, 8'h0A, 16'hE5E5, 0);
    do_pr(1'b1, 8'h0E, 16'hF6F6, 0);       // R8: writeback then read-exclusive
    // R10: snoop and processor read together; snoop served first
    pv = 1'b1; pw = 1'b0; pa = 8'h0E; sv = 1'b1; sx = 1'b1; sa = 8'h0E;
    tick();
    sv = 1'b0;
    do_pr(1'b0, 8'h0E, 16'h0, 0);          // R10: now misses
    // R12 and mixed ordering: random traffic with concurrent snoops
    for (int k = 0; k < 300; k++) begin
      logic [7:0] r;
      r = rnd8();
      do_pr(r[0], {4'd0, rnd8() % 8'd16}, {rnd8(), rnd8()}, 30);
      if (r[5:4] == 2'd0) snoop(r[6], {4'd0, rnd8() % 8'd16});
    end
    tick();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule